// File: doc/BRIEF.md
# Vector Modified-Immediate Classifier and Apply Unit

This unit executes the vector "modified immediate" family of operations. It receives a one-bit op selector, a four-bit cmode selector, a Q bit choosing full 128-bit or lower-64-bit width, an eight-bit immediate and the current contents of the destination vector. From the five-bit op:cmode code it picks exactly one operation class: plain move, inverted move, OR-with-immediate, bit-clear-with-immediate or double-precision floating move. It expands the byte to a 64-bit pattern and forms the 128-bit value to be written back.

The unit is a single pipeline stage. A request presented with `inValid` high produces, on the next clock, either `wrEn` with the new destination value on `result`, or `illegal` for a code with no defined meaning. The register file and any floating-point arithmetic sit outside the unit.

Top module: `simdImmUnit`

## Requirements
- R1: After reset `wrEn` and `illegal` are low and `result` is all zeros.
- R2: `wrEn` or `illegal` rises exactly one cycle after a clock edge with `inValid` high, and both stay low one cycle after a clock edge with `inValid` low; `result` then holds its previous value.
- R3: Codes op:cmode 0:0xx0, 0:10x0, 0:110x, 0:1110 and 1:1110 are plain moves: the low 64 bits of `result` equal the expanded pattern.
- R4: Codes 1:0xx0, 1:10x0 and 1:110x are inverted moves: the low 64 bits are the bitwise complement of the expanded pattern.
- R5: Codes 0:0xx1 and 0:10x1 write the destination ORed with the pattern.
- R6: Codes 1:0xx1 and 1:10x1 write the destination with every bit that is set in the pattern cleared.
- R7: Code 1:1111 is a floating move and is legal only with Q=1; code 0:1111, and 1:1111 with Q=0, raise `illegal` with `wrEn` low and `result` all zeros.
- R8: Each legal code selects exactly one class, and `wrEn` and `illegal` are never high together.
- R9: With Q=0 the upper 64 bits of `result` are zero for every class; with Q=1 the upper half receives the same operation as the lower half, applied to the upper half of the destination.
- R10: For cmode 0xx the pattern is the byte shifted left by 8*cmode[2:1] inside a 32-bit lane, repeated in both lanes.
- R11: For cmode 10x the pattern is the byte shifted left by 8*cmode[1] inside a 16-bit lane, repeated in all four lanes.
- R12: For cmode 110x each 32-bit lane is the byte shifted left by 8 (cmode[0]=0) or 16 (cmode[0]=1) with ones filling the bits below it and zeros above.
- R13: For cmode 1110 with op=0 the byte is repeated in all eight byte positions; with op=1 byte k of the pattern is 0xFF when immediate bit k is set and 0x00 otherwise.
- R14: For code 1:1111 the pattern is, from bit 63 down: immediate bit 7, the inverse of bit 6, bit 6 repeated eight times, bits 5..0, then 48 zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| op | input | 1 | Operation selector bit |
| cmode | input | 4 | Mode selector field |
| q | input | 1 | 1 = full 128-bit width, 0 = lower 64 bits only |
| imm8 | input | 8 | Packed immediate byte |
| dstVec | input | 128 | Current destination vector contents |
| result | output | 128 | Value to write to the destination |
| wrEn | output | 1 | Write enable for `result` |
| illegal | output | 1 | The requested code is undefined |

## Verification
The assertions assume that `op`, `cmode`, `q`, `imm8` and `dstVec` are stable and known whenever `inValid` is high at a clock edge, since both the class decode and the registered result are taken from them in that cycle. They also assume `inValid` is driven low during reset so the first post-reset cycle does not report a stale request. The bench drives every input on the falling edge and returns `inValid` to zero between requests, so each request is seen at exactly one rising edge, and it sweeps all 32 codes at both widths against a model built separately from the requirements.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;
  localparam int VEC_W  = 128;
  localparam int HALF_W = VEC_W / 2;
  localparam int IMM_W  = 8;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic isMove;
    logic isMoveInv;
    logic isOrr;
    logic isBic;
    logic isFmov;
    logic legal;
  } ctlStrobe_t;
endpackage

// File: rtl/simdImmCtrl.sv
module simdImmCtrl
  import simd_imm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       op,
  input  logic [3:0] cmode,
  input  logic       q,
  output ctlStrobe_t strobe,
  output logic       wrEn,
  output logic       illegal
);
  logic [CODE_W-1:0] code;
  assign code = {op, cmode};

  always_comb begin
    strobe = '0;
    casez (code)
      5'b0_0??0, 5'b0_10?0, 5'b0_110?, 5'b?_1110: strobe.isMove    = 1'b1;
      5'b1_0??0, 5'b1_10?0, 5'b1_110?:            strobe.isMoveInv = 1'b1;
      5'b0_0??1, 5'b0_10?1:                       strobe.isOrr     = 1'b1;
      5'b1_0??1, 5'b1_10?1:                       strobe.isBic     = 1'b1;
      5'b1_1111:                                  strobe.isFmov    = q;
      default:                                    strobe           = '0;
    endcase
    strobe.legal = strobe.isMove | strobe.isMoveInv | strobe.isOrr |
                   strobe.isBic | strobe.isFmov;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      wrEn    <= inValid & strobe.legal;
      illegal <= inValid & ~strobe.legal;
    end
  end

  // R8: at most one class flag is raised
  p_one_class_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.isMove, strobe.isMoveInv, strobe.isOrr, strobe.isBic, strobe.isFmov}));

  // R7: floating move only with full width
  p_fmov_needs_q_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.isFmov |-> q);

  // R8: outcome flags exclusive
  p_excl_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && illegal));

  // R2: any outcome follows a request
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (wrEn || illegal));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!wrEn && !illegal));
endmodule

// File: rtl/simdImmDatapath.sv
module simdImmDatapath
  import simd_imm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             op,
  input  logic [3:0]       cmode,
  input  logic             q,
  input  logic [IMM_W-1:0] imm8,
  input  logic [VEC_W-1:0] dstVec,
  input  ctlStrobe_t       strobe,
  output logic [VEC_W-1:0] result
);
  localparam int NBYTES = HALF_W / 8;

  logic [HALF_W-1:0] bitBytes;
  logic [HALF_W-1:0] fpPat;
  logic [HALF_W-1:0] pattern;
  logic [31:0]       lane32;
  logic [15:0]       lane16;
  logic [HALF_W-1:0] loVal, hiFull, hiVal;

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_bitByte
      assign bitBytes[g*8 +: 8] = {8{imm8[g]}};
    end
  endgenerate

  assign fpPat = {imm8[7], ~imm8[6], {8{imm8[6]}}, imm8[5:0], 48'h0};

  always_comb begin
    lane32  = '0;
    lane16  = '0;
    pattern = '0;
    if (!cmode[3]) begin
      lane32  = {24'h0, imm8} << {cmode[2:1], 3'b000};
      pattern = {2{lane32}};
    end else if (cmode[3:2] == 2'b10) begin
      lane16  = {8'h0, imm8} << {cmode[1], 3'b000};
      pattern = {4{lane16}};
    end else if (cmode[3:1] == 3'b110) begin
      lane32  = cmode[0] ? {8'h00, imm8, 16'hFFFF} : {16'h0000, imm8, 8'hFF};
      pattern = {2{lane32}};
    end else if (!cmode[0]) begin
      pattern = op ? bitBytes : {NBYTES{imm8}};
    end else begin
      pattern = fpPat;
    end
  end

  function automatic logic [HALF_W-1:0] applyHalf(input ctlStrobe_t s,
                                                   input logic [HALF_W-1:0] pat,
                                                   input logic [HALF_W-1:0] dst);
    if (s.isMoveInv)  return ~pat;
    else if (s.isOrr) return dst | pat;
    else if (s.isBic) return dst & ~pat;
    else              return pat;
  endfunction

  always_comb begin
    loVal  = applyHalf(strobe, pattern, dstVec[HALF_W-1:0]);
    hiFull = applyHalf(strobe, pattern, dstVec[VEC_W-1:HALF_W]);
    hiVal  = q ? hiFull : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        result <= '0;
    else if (inValid) result <= strobe.legal ? {hiVal, loVal} : '0;
  end

  // R7: undefined code leaves a cleared result
  p_illegal_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strobe.legal) |=> (result == '0));

  // R9: half width zeroes the upper half
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !q) |=> (result[VEC_W-1:HALF_W] == '0));

  // R2: no request, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
endmodule

// File: rtl/simdImmUnit.sv
module simdImmUnit
  import simd_imm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         op,
  input  logic [3:0]   cmode,
  input  logic         q,
  input  logic [7:0]   imm8,
  input  logic [127:0] dstVec,
  output logic [127:0] result,
  output logic         wrEn,
  output logic         illegal
);
  ctlStrobe_t strobe;

  simdImmCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .cmode(cmode), .q(q),
    .strobe(strobe), .wrEn(wrEn), .illegal(illegal)
  );

  simdImmDatapath u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .cmode(cmode), .q(q),
    .imm8(imm8), .dstVec(dstVec), .strobe(strobe), .result(result)
  );

  // R8: illegal result never written
  p_illegal_no_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (result == '0));
endmodule

// File: tb/simdImmUnit_bench.sv
module simdImmUnit_bench;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         op;
  logic [3:0]   cmode;
  logic         q;
  logic [7:0]   imm8;
  logic [127:0] dstVec;
  logic [127:0] result;
  logic         wrEn;
  logic         illegal;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  simdImmUnit u_simdImmUnit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .cmode(cmode), .q(q),
    .imm8(imm8), .dstVec(dstVec), .result(result), .wrEn(wrEn), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: returns legality and 128-bit value
  function automatic bit model(input logic o, input logic [3:0] c, input logic qq,
                               input logic [7:0] b, input logic [127:0] d,
                               output logic [127:0] v);
    logic [63:0] p, lo, hi;
    int kind; // 0 move 1 inv 2 orr 3 bic
    p = 64'h0;
    for (int lane = 0; lane < 2; lane++) begin
      if (c[3] == 1'b0)
        p[lane*32 +: 32] = 32'(b) << (8 * int'(c[2:1]));
      else if (c[3:1] == 3'b110)
        p[lane*32 +: 32] = c[0] ? (32'(b) << 16) | 32'h0000FFFF
                                : (32'(b) << 8)  | 32'h000000FF;
    end
    if (c[3:2] == 2'b10)
      for (int h = 0; h < 4; h++) p[h*16 +: 16] = 16'(b) << (c[1] ? 8 : 0);
    if (c == 4'b1110)
      for (int k = 0; k < 8; k++) p[k*8 +: 8] = o ? (b[k] ? 8'hFF : 8'h00) : b;
    if (c == 4'b1111) begin
      p = 64'h0;
      p[63] = b[7]; p[62] = ~b[6];
      for (int k = 54; k <= 61; k++) p[k] = b[6];
      p[53:48] = b[5:0];
    end
    v = '0;
    if (c == 4'b1111 && !(o && qq)) return 1'b0;
    if (c == 4'b1110 || c == 4'b1111) kind = 0;
    else if (c[3:1] == 3'b110) kind = o ? 1 : 0;
    else kind = (o ? 1 : 0) + (c[0] ? 2 : 0);
    case (kind)
      0: begin lo = p; hi = p; end
      1: begin lo = ~p; hi = ~p; end
      2: begin lo = d[63:0] | p; hi = d[127:64] | p; end
      default: begin lo = d[63:0] & ~p; hi = d[127:64] & ~p; end
    endcase
    v = {qq ? hi : 64'h0, lo};
    return 1'b1;
  endfunction

  task automatic issue(input logic o, input logic [3:0] c, input logic qq,
                       input logic [7:0] b, input logic [127:0] d);
    @(negedge clk);
    op = o; cmode = c; q = qq; imm8 = b; dstVec = d; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runAndCheck(input logic o, input logic [3:0] c, input logic qq,
                             input logic [7:0] b, input logic [127:0] d, input string req);
    logic [127:0] ev;
    bit lg;
    lg = model(o, c, qq, b, d, ev);
    issue(o, c, qq, b, d);
    check(wrEn == lg && illegal == !lg, {req, " flags"}, {126'h0, wrEn, illegal}, {126'h0, lg, !lg});
    check(result == ev, req, result, ev);
  endtask

  task automatic testReset();
    check(!wrEn && !illegal && result == '0, "R1 reset", result, 128'h0);
  endtask

  task automatic testShapes();
    // R10: 32-bit shift by 16
    runAndCheck(1'b0, 4'b0100, 1'b0, 8'hAB, '0, "R10 shift32");
    check(result[63:0] == 64'h00AB0000_00AB0000, "R10 literal", result, 128'h00AB000000AB0000);
    // R11: 16-bit shift by 8, full width
    runAndCheck(1'b0, 4'b1010, 1'b1, 8'h3C, '0, "R11 shift16");
    check(result == {2{64'h3C003C003C003C00}}, "R11 literal", result, {2{64'h3C003C003C003C00}});
    // R12: ones fill
    runAndCheck(1'b0, 4'b1101, 1'b0, 8'h5A, '0, "R12 ones16");
    check(result[63:0] == 64'h005AFFFF_005AFFFF, "R12 literal", result, 128'h005AFFFF005AFFFF);
    // R13: bit-to-byte and replicate
    runAndCheck(1'b1, 4'b1110, 1'b1, 8'hA5, '0, "R13 bitbyte");
    check(result[63:0] == 64'hFF00FF0000FF00FF, "R13 literal", result, 128'hFF00FF0000FF00FF);
    runAndCheck(1'b0, 4'b1110, 1'b0, 8'h96, '0, "R13 replicate");
    // R14: encodes 1.0
    runAndCheck(1'b1, 4'b1111, 1'b1, 8'h70, '0, "R14 fpattern");
    check(result == {2{64'h3FF0000000000000}}, "R14 literal", result, {2{64'h3FF0000000000000}});
  endtask

  task automatic testClasses();
    logic [127:0] d = 128'hF0F0_1234_5678_9ABC_0FED_CBA9_8765_4321;
    runAndCheck(1'b0, 4'b0010, 1'b1, 8'h81, d, "R3 move");
    runAndCheck(1'b1, 4'b1000, 1'b1, 8'h81, d, "R4 inverted");
    check(result[63:0] == 64'hFF7EFF7EFF7EFF7E, "R4 literal", result, 128'hFF7EFF7EFF7EFF7E);
    runAndCheck(1'b0, 4'b0001, 1'b1, 8'hFF, d, "R5 orr");
    runAndCheck(1'b1, 4'b1011, 1'b1, 8'hFF, d, "R6 bic");
    runAndCheck(1'b1, 4'b0111, 1'b0, 8'hFF, d, "R9 bic half");
  endtask

  task automatic testIllegal();
    runAndCheck(1'b0, 4'b1111, 1'b1, 8'h70, 128'h1, "R7 op0 fp");
    check(illegal && !wrEn, "R7 flag", {126'h0, wrEn, illegal}, 128'h1);
    runAndCheck(1'b1, 4'b1111, 1'b0, 8'h70, 128'h1, "R7 q0 fp");
  endtask

  task automatic testIdle();
    logic [127:0] keep;
    runAndCheck(1'b0, 4'b0000, 1'b1, 8'h11, '0, "R2 seed");
    keep = result;
    @(negedge clk);
    imm8 = 8'hEE; cmode = 4'b0110;
    @(negedge clk);
    check(!wrEn && !illegal, "R2 idle flags", {126'h0, wrEn, illegal}, 128'h0);
    check(result == keep, "R2 hold", result, keep);
  endtask

  task automatic testSweep();
    for (int code = 0; code < 32; code++)
      for (int qq = 0; qq < 2; qq++)
        runAndCheck(code[4], code[3:0], qq[0], 8'hC7,
                    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R8 R9 sweep");
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; op = 1'b0; cmode = '0; q = 1'b0;
    imm8 = '0; dstVec = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testShapes();
    testClasses();
    testIllegal();
    testIdle();
    testSweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule